// File: doc/BRIEF.md
# Converter Sequencing and Register Block

This block is the digital side of an eight-channel, ten-bit successive-approximation converter. Software reaches it through a 32-bit register port holding two words: a control word at offset 0x00 and a result word at offset 0x04. Through the control word the host sets a channel, a clock divider, a reference choice and two enables, then requests a conversion. The block forwards the request to the analog macro as a one-cycle start pulse with the channel number. It waits for the macro's done strobe, captures the ten-bit result and raises a completion flag.

The completion flag is write-one-to-clear, and it drives an interrupt through an enable mask. A conversion clock for the macro is derived from the input clock by a programmable even divider. A soft-reset bit in the control word aborts any conversion and holds the sequencer idle until software releases it.

Top module: `conv_ctrl_top`

## Requirements
- R1: After reset the control word and the result word read 0x00000000, and irq, convStart, convClk and refInternal are all 0.
- R2: The control word keeps these fields: channel in bits 26:24, interrupt enable in bit 21, reference select in bit 19, converter enable in bit 17, soft reset in bit 16 and divider N in bits 8:1. Bit 27 and every unused bit read 0. Bits 13 and 18 cannot be set by a write, so writing 0xFFFFFFFF reads back 0x072B01FE. Any address other than 0x00 and 0x04 reads 0.
- R3: A write to the control word with bit 13 = 1, bit 17 = 1 and bit 16 = 0 while idle produces convStart high for exactly one clock cycle. During that pulse convChan equals the channel field. Bit 13 then reads 1 until the conversion completes.
- R4: A convDone strobe during a conversion clears bit 13 and sets bit 18. The result word then reads convResult in bits 9:0, with bits 31:10 equal to 0.
- R5: The result word holds its value until the next completion. A convDone strobe with no conversion in progress changes neither the result nor bit 18.
- R6: Writing the control word with bit 18 = 1 clears the completion flag. Writing it with bit 18 = 0 leaves the flag unchanged.
- R7: irq is 1 exactly when bit 18 and bit 21 are both 1.
- R8: A start request written while bit 17 is 0 produces no convStart, and bit 13 stays 0.
- R9: Writing bit 16 = 1 aborts a conversion in progress and clears bits 13 and 18. While bit 16 stays 1, convDone is ignored and start requests produce no convStart.
- R10: With bit 17 = 1 and bit 16 = 0, convClk has a period of 2*(N+1) input clock cycles. Otherwise convClk is held at 0.
- R11: refInternal follows control bit 19: 1 selects the internal reference, 0 the external one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read enable; rdData is 0 when low |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addr |
| convStart | output | 1 | One-cycle start pulse to the analog macro |
| convChan | output | 3 | Selected channel |
| convDone | input | 1 | Completion strobe from the analog macro |
| convResult | input | 10 | Result from the analog macro, valid with convDone |
| convClk | output | 1 | Divided conversion clock |
| refInternal | output | 1 | Reference select, 1 = internal |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to create from the ports is a conversion that is aborted by soft reset. This is followed by a stale done strobe from the analog model, and then a start request written while reset is still held. The bench starts a conversion and writes the reset bit before it strobes done. It then fires done and a start request while reset is held, and checks that neither the result word, the flag nor the start counter moves. Finally it releases reset with a fresh start and confirms that a normal conversion follows.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_CONV   = 13;
  localparam int BIT_SRST   = 16;
  localparam int BIT_EN     = 17;
  localparam int BIT_DONE   = 18;
  localparam int BIT_REF    = 19;
  localparam int BIT_IE     = 21;
  localparam int CHAN_LSB   = 24;
  localparam int DIV_LSB    = 1;
  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] DATA_OFS = 8'h04;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_WAIT  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic latchResult;
    logic divEnable;
  } ctlStrobe_t;
endpackage

// File: rtl/conv_ctrl_ctl.sv
module conv_ctrl_ctl
  import conv_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_W = 3,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              convDone,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output logic              refInternal,
  output logic              irq,
  output logic [REG_W-1:0]  ctrlWord,
  output logic [DIV_W-1:0]  divVal,
  output ctlStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic              enReg, ieReg, refReg, srstReg, statusReg;
  logic [CHAN_W-1:0] chanReg;
  logic [DIV_W-1:0]  divReg;
  seqState_t         state;

  logic wrCtrl, nextSrst, startReq, doneAccept, busy;

  assign wrCtrl     = wrEn && (addr == CTRL_ADDR);
  assign nextSrst   = wrCtrl ? wrData[BIT_SRST] : srstReg;
  assign startReq   = wrCtrl && wrData[BIT_CONV] && wrData[BIT_EN] &&
                      !wrData[BIT_SRST] && (state == SEQ_IDLE);
  assign doneAccept = (state == SEQ_WAIT) && convDone && !nextSrst;
  assign busy       = (state != SEQ_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      ieReg   <= 1'b0;
      refReg  <= 1'b0;
      srstReg <= 1'b0;
      chanReg <= '0;
      divReg  <= '0;
    end else if (wrCtrl) begin
      enReg   <= wrData[BIT_EN];
      ieReg   <= wrData[BIT_IE];
      refReg  <= wrData[BIT_REF];
      srstReg <= wrData[BIT_SRST];
      chanReg <= wrData[CHAN_LSB +: CHAN_W];
      divReg  <= wrData[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
    end else if (nextSrst) begin
      state <= SEQ_IDLE;
    end else begin
      unique case (state)
        SEQ_IDLE:  if (startReq) state <= SEQ_START;
        SEQ_START: state <= SEQ_WAIT;
        SEQ_WAIT:  if (convDone) state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                statusReg <= 1'b0;
    else if (nextSrst)                        statusReg <= 1'b0;
    else if (doneAccept)                      statusReg <= 1'b1;
    else if (wrCtrl && wrData[BIT_DONE])      statusReg <= 1'b0;
  end

  always_comb begin
    ctrlWord                         = '0;
    ctrlWord[CHAN_LSB +: CHAN_W]     = chanReg;
    ctrlWord[BIT_IE]                 = ieReg;
    ctrlWord[BIT_REF]                = refReg;
    ctrlWord[BIT_DONE]               = statusReg;
    ctrlWord[BIT_EN]                 = enReg;
    ctrlWord[BIT_SRST]               = srstReg;
    ctrlWord[BIT_CONV]               = busy;
    ctrlWord[DIV_LSB +: DIV_W]       = divReg;
  end

  assign convStart          = (state == SEQ_START);
  assign convChan           = chanReg;
  assign refInternal        = refReg;
  assign irq                = statusReg && ieReg;
  assign divVal             = divReg;
  assign strobe.latchResult = doneAccept;
  assign strobe.divEnable   = enReg && !srstReg;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> enReg); // R8
  AST_SRST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    srstReg |-> (!busy && !statusReg)); // R9
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !srstReg) |-> statusReg); // R4
endmodule

// File: rtl/conv_ctrl_dp.sv
module conv_ctrl_dp
  import conv_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DIV_W-1:0]  divVal,
  input  logic [RES_W-1:0]  convResult,
  input  logic [REG_W-1:0]  ctrlWord,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_W-1:0]  rdData,
  output logic              convClk
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFS);

  logic [RES_W-1:0] resultReg;
  logic [DIV_W-1:0] divCnt;
  logic             clkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   resultReg <= '0;
    else if (strobe.latchResult) resultReg <= convResult;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      clkReg <= 1'b0;
    end else if (!strobe.divEnable) begin
      divCnt <= '0;
      clkReg <= 1'b0;
    end else if (divCnt >= divVal) begin
      divCnt <= '0;
      clkReg <= ~clkReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign convClk = clkReg;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == CTRL_ADDR)      rdData = ctrlWord;
      else if (addr == DATA_ADDR) rdData = REG_W'(resultReg);
    end
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchResult |=> $stable(resultReg)); // R5
  AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.divEnable |=> !convClk); // R10
endmodule

// File: rtl/conv_ctrl_top.sv
module conv_ctrl_top
  import conv_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAN_W = 3,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              convClk,
  output logic              refInternal,
  output logic              irq
);
  logic [REG_W-1:0] ctrlWord;
  logic [DIV_W-1:0] divVal;
  ctlStrobe_t       strobe;

  conv_ctrl_ctl #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .convDone(convDone), .convStart(convStart), .convChan(convChan),
    .refInternal(refInternal), .irq(irq), .ctrlWord(ctrlWord),
    .divVal(divVal), .strobe(strobe)
  );

  conv_ctrl_dp #(.ADDR_W(ADDR_W), .RES_W(RES_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .divVal(divVal),
    .convResult(convResult), .ctrlWord(ctrlWord), .rdEn(rdEn), .addr(addr),
    .rdData(rdData), .convClk(convClk)
  );
endmodule

// File: tb/conv_ctrl_top_tb.sv
module conv_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN   = 32'h0002_0000;
  localparam logic [31:0] IE   = 32'h0020_0000;
  localparam logic [31:0] CONV = 32'h0000_2000;
  localparam logic [31:0] SRST = 32'h0001_0000;
  localparam logic [31:0] FLAG = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        convStart;
  logic [2:0]  convChan;
  logic        convDone = 1'b0;
  logic [9:0]  convResult = '0;
  logic        convClk, refInternal, irq;

  int checks = 0;
  int failures = 0;
  int startCount = 0;
  logic [2:0] lastChan = '0;
  logic prevStart = 1'b0;
  logic longPulse = 1'b0;
  bit   done = 0;

  conv_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .convStart(convStart),
    .convChan(convChan), .convDone(convDone), .convResult(convResult),
    .convClk(convClk), .refInternal(refInternal), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    prevStart <= convStart;
    if (convStart) begin
      startCount <= startCount + 1;
      lastChan   <= convChan;
      if (prevStart) longPulse <= 1'b1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic pulseDone(logic [9:0] v);
    @(negedge clk);
    convDone = 1'b1; convResult = v;
    @(negedge clk);
    convDone = 1'b0; convResult = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    regRead(8'h00, v); check("R1 ctrl", v, 0);
    regRead(8'h04, v); check("R1 data", v, 0);
    check("R1 pins", {28'b0, irq, convStart, convClk, refInternal}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    int s0 = startCount;
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h00, v); check("R2 readback mask", v, 32'h072B_01FE);
    check("R11 ref internal", {31'b0, refInternal}, 1);
    idle(3); check("R2 no start with srst", startCount, s0);
    regRead(8'h08, v); check("R2 unmapped reads 0", v, 0);
    regWrite(8'h00, 32'h0);
    regRead(8'h00, v); check("R2 cleared", v, 0);
    check("R11 ref external", {31'b0, refInternal}, 0);
  endtask

  task automatic t_disabled_start();
    logic [31:0] v;
    int s0 = startCount;
    regWrite(8'h00, CONV | IE);
    idle(3);
    check("R8 no pulse", startCount, s0);
    regRead(8'h00, v); check("R8 busy stays 0", v & CONV, 0);
  endtask

  task automatic t_convert(logic [2:0] ch, logic [9:0] res, logic withIe);
    logic [31:0] v;
    int s0 = startCount;
    logic [31:0] base = EN | (withIe ? IE : 0) | (32'(ch) << 24);
    regWrite(8'h00, base | CONV);
    regRead(8'h00, v); check("R3 busy set", v & CONV, CONV);
    idle(3);
    check("R3 one pulse", startCount, s0 + 1);
    check("R3 channel", {29'b0, lastChan}, {29'b0, ch});
    check("R3 pulse width", {31'b0, longPulse}, 0);
    regRead(8'h00, v); check("R3 busy held", v & CONV, CONV);
    pulseDone(res);
    regRead(8'h00, v); check("R4 busy cleared and flag set", v & (CONV | FLAG), FLAG);
    regRead(8'h04, v); check("R4 data", v, {22'b0, res});
    check("R7 irq", {31'b0, irq}, {31'b0, withIe});
  endtask

  task automatic t_hold_and_w1c();
    logic [31:0] v;
    pulseDone(10'h155);
    regRead(8'h04, v); check("R5 stray done ignored", v, 32'h0000_02A7);
    regWrite(8'h00, EN | IE | (32'd5 << 24));
    regRead(8'h00, v); check("R6 write 0 keeps flag", v & FLAG, FLAG);
    check("R7 irq still set", {31'b0, irq}, 1);
    regWrite(8'h00, EN | IE | FLAG);
    regRead(8'h00, v); check("R6 write 1 clears flag", v & FLAG, 0);
    check("R7 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    int s0;
    regWrite(8'h00, EN | IE | CONV | (32'd3 << 24));
    idle(2);
    regWrite(8'h00, EN | IE | SRST);
    regRead(8'h00, v); check("R9 abort clears busy and flag", v & (CONV | FLAG), 0);
    pulseDone(10'h0AA);
    regRead(8'h04, v); check("R9 done ignored in reset", v, 32'h0000_0001);
    regRead(8'h00, v); check("R9 flag stays 0", v & FLAG, 0);
    s0 = startCount;
    regWrite(8'h00, EN | IE | SRST | CONV);
    idle(3); check("R9 start ignored in reset", startCount, s0);
    regWrite(8'h00, EN | IE | CONV | (32'd6 << 24));
    idle(2); check("R9 start after release", startCount, s0 + 1);
    pulseDone(10'h3C3);
    regRead(8'h04, v); check("R9 conversion after release", v, 32'h0000_03C3);
    regWrite(8'h00, FLAG);
  endtask

  task automatic t_divider(logic [7:0] n);
    int cnt = 0;
    int guard = 0;
    logic prev;
    regWrite(8'h00, EN | (32'(n) << 1));
    prev = convClk;
    while (!(prev == 1'b0 && convClk == 1'b1) && guard < 2000) begin
      prev = convClk; @(negedge clk); guard++;
    end
    prev = convClk;
    @(negedge clk); cnt = 1;
    while (!(prev == 1'b0 && convClk == 1'b1) && cnt < 2000) begin
      prev = convClk; @(negedge clk); cnt++;
    end
    check("R10 period", cnt, 2 * (int'(n) + 1));
    regWrite(8'h00, EN | SRST | (32'(n) << 1));
    idle(2 * (int'(n) + 2));
    check("R10 held low in reset", {31'b0, convClk}, 0);
    regWrite(8'h00, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_fields();
    t_disabled_start();
    t_convert(3'd4, 10'h2A7, 1'b1);
    t_hold_and_w1c();
    t_convert(3'd7, 10'h001, 1'b0);
    t_soft_reset();
    t_divider(8'd0);
    t_divider(8'd2);
    t_divider(8'd5);
    finishRun();
  end
endmodule